// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches four external interrupt pads. A 2-bit sense field per pad selects how that pad raises a request: a low level on the pad, a falling edge, a rising edge, or any change. Edge events are caught by a two-flop synchroniser and a stored previous sample. They set a flag that stays set until software clears it with a write-one pulse. Low-level requests are not latched. They follow the raw pad combinationally, so they need no clock. A request is the flag, or the live low level, qualified by the pad's enable bit. The wake output is the OR of all requests.

The input `clk_io` is the root clock. `io_run` is the gate of the I/O clock, and it is low in every sleep mode except idle. While the gate is off, all edge logic is frozen, so edges are not recognised. A low level on a pad still reaches `wake_o` during this time. When the gate reopens, the synchroniser is refilled before edge detection is armed again. A pad that changed during sleep therefore does not produce a false edge.

A small gate controller holds the state. **GS_HALT** means the I/O clock is off. **GS_FILL** means the synchroniser is refilling and detection is disarmed. **GS_RUN** means edges are detected. The transitions are:
- *gate_off*: any state goes to GS_HALT when `io_run` is low.
- *gate_on*: GS_HALT goes to GS_FILL when `io_run` is high.
- *filled*: GS_FILL goes to GS_RUN after SYNC_STAGES+1 gated cycles.

Reset enters GS_FILL.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, `flag_o`, `irq_o` and `wake_o` are all zero while the pads are high.
- R2: Sense code 2'b10 (falling edge) sets the pad's flag on a 1-to-0 pad change. The flag is visible after the third rising clock edge following the change. A 0-to-1 change sets nothing.
- R3: Sense code 2'b11 (rising edge) sets the flag only on a 0-to-1 change, with the same three-cycle latency.
- R4: Sense code 2'b01 (any change) sets the flag on both directions of change.
- R5: Sense code 2'b00 (low level) never sets a flag. `irq_o[i]` equals `en_i[i] & ~pin_i[i]` combinationally, with no clock involved.
- R6: A set flag stays set until a one on `clr_i[i]` at a clock edge clears it.
- R7: When an edge is detected and a clear arrives in the same cycle, the flag ends set.
- R8: `irq_o[i]` is low whenever `en_i[i]` is low. An edge on a disabled pad still sets its flag.
- R9: `wake_o` is high exactly when any bit of `irq_o` is high.
- R10: While `io_run` is low, no flag is set. Pad changes made while it is low produce no flag after `io_run` returns. Edge detection resumes SYNC_STAGES+2 cycles after `io_run` rises.
- R11: Switching a pad's sense field to low level clears its flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | Root clock for the I/O domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_run | input | 1 | I/O clock gate, low in deep sleep |
| pin_i | input | 4 | External interrupt pads |
| sense_i | input | 8 | 2-bit sense code per pad, pad i at bits 2i+1:2i |
| en_i | input | 4 | Per-pad interrupt enable |
| clr_i | input | 4 | Write-one-to-clear pulses for the flags |
| flag_o | output | 4 | Latched edge flags |
| irq_o | output | 4 | Per-pad interrupt request |
| wake_o | output | 1 | Combined request, usable as a wake signal |

## Verification
Suppose the gate controller is stuck in GS_RUN, or leaves GS_FILL too early. A pad that moved during sleep then raises a flag about three cycles after `io_run` rises, where the expected vector is zero. Suppose the stored previous sample or the synchroniser is wrong. The flag then appears one cycle early or late, or on the wrong edge direction, and the bench samples it on the exact cycle. Errors in the level path show at `irq_o` and `wake_o` one cycle after the pad moves, even while the gate is off.

// File: rtl/eis_pkg.sv
package eis_pkg;
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        GS_HALT = 2'b00,
        GS_FILL = 2'b01,
        GS_RUN  = 2'b10
    } gate_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '1;
        end else if (tick) begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/eis_gate.sv
module eis_gate
    import eis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  io_run,
    output logic  tick,
    output logic  arm,
    output gate_e state_o
);
    localparam int CW = $clog2(SYNC_STAGES + 1);
    localparam logic [CW-1:0] LIM = CW'(SYNC_STAGES);

    gate_e         state, nxt;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GS_FILL;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state != GS_FILL)  cnt <= '0;
            else if (cnt != LIM)   cnt <= cnt + 1'b1;
        end
    end

    // transitions: gate_off, gate_on, filled
    always_comb begin
        nxt = state;
        unique case (state)
            GS_HALT: if (io_run) nxt = GS_FILL;
            GS_FILL: begin
                if (!io_run)         nxt = GS_HALT;
                else if (cnt == LIM) nxt = GS_RUN;
            end
            GS_RUN:  if (!io_run) nxt = GS_HALT;
            default: nxt = GS_HALT;
        endcase
    end

    // outputs
    always_comb begin
        tick    = io_run;
        arm     = io_run && (state == GS_RUN);
        state_o = state;
    end
endmodule

// File: rtl/eis_edge_cell.sv
module eis_edge_cell
    import eis_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   arm,
    input  logic   s,
    input  sense_e mode,
    input  logic   clr,
    output logic   flag
);
    logic prev;
    logic ev;

    always_comb begin
        unique case (mode)
            SNS_ANY:  ev = s ^ prev;
            SNS_FALL: ev = prev & ~s;
            SNS_RISE: ev = ~prev & s;
            default:  ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b1;
            flag <= 1'b0;
        end else begin
            if (tick) prev <= s;
            if (mode == SNS_LOW)  flag <= 1'b0;
            else if (arm && ev)   flag <= 1'b1;
            else if (clr)         flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_io,
    input  logic               rst_n,
    input  logic               io_run,
    input  logic [NPINS-1:0]   pin_i,
    input  logic [2*NPINS-1:0] sense_i,
    input  logic [NPINS-1:0]   en_i,
    input  logic [NPINS-1:0]   clr_i,
    output logic [NPINS-1:0]   flag_o,
    output logic [NPINS-1:0]   irq_o,
    output logic               wake_o
);
    logic             tick, arm;
    gate_e            gs;
    logic [NPINS-1:0] pin_s;

    eis_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk(clk_io), .rst_n(rst_n), .io_run(io_run),
        .tick(tick), .arm(arm), .state_o(gs)
    );

    eis_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_io), .rst_n(rst_n), .tick(tick), .d(pin_i), .q(pin_s)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        sense_e md;
        assign md = sense_e'(sense_i[2*i +: 2]);

        eis_edge_cell u_cell (
            .clk(clk_io), .rst_n(rst_n), .tick(tick), .arm(arm),
            .s(pin_s[i]), .mode(md), .clr(clr_i[i]), .flag(flag_o[i])
        );

        // level path is purely combinational: works with the I/O clock off
        assign irq_o[i] = en_i[i] & ((md == SNS_LOW) ? ~pin_i[i] : flag_o[i]);
    end

    assign wake_o = |irq_o;
endmodule

// File: rtl/eis_chk.sv
module eis_chk
    import eis_pkg::*;
#(
    parameter int NPINS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_run,
    input logic [2*NPINS-1:0] sense,
    input logic [NPINS-1:0]   en,
    input logic [NPINS-1:0]   flag,
    input logic [NPINS-1:0]   irq,
    input logic               wake,
    input gate_e              gs
);
    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~en) == '0);

    // R9
    wake_is_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake == (irq != '0));

    // R10
    no_set_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gs != GS_RUN || !io_run) |=> ((flag & ~$past(flag)) == '0));

    // R10
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_run |=> gs == GS_HALT);

    for (genvar i = 0; i < NPINS; i++) begin : g_c
        // R11
        low_mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sense[2*i +: 2] == 2'b00) |=> !flag[i]);
    end
endmodule

bind ext_irq_sense eis_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk_io), .rst_n(rst_n), .io_run(io_run), .sense(sense_i),
    .en(en_i), .flag(flag_o), .irq(irq_o), .wake(wake_o), .gs(gs)
);

// File: tb/tb_ext_irq_sense.sv
`timescale 1ns/1ps
module tb_ext_irq_sense;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_run = 1'b1;
    logic [3:0] pin = 4'hF;
    logic [7:0] sense = 8'b00_01_11_10;
    logic [3:0] en = 4'hF;
    logic [3:0] clr = 4'h0;
    logic [3:0] flag, irq;
    logic       wake;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        int         due;
        logic [3:0] f;
        logic [3:0] q;
        logic       w;
        string      rid;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    ext_irq_sense dut (
        .clk_io(clk), .rst_n(rst_n), .io_run(io_run), .pin_i(pin),
        .sense_i(sense), .en_i(en), .clr_i(clr),
        .flag_o(flag), .irq_o(irq), .wake_o(wake)
    );

    task automatic expect_in(int k, logic [3:0] f, logic [3:0] q, logic w, string rid);
        item_t it;
        it.due = cyc + k; it.f = f; it.q = q; it.w = w; it.rid = rid;
        sb.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wipe(logic [3:0] m, string rid);
        clr = m;
        expect_in(1, 4'h0, 4'h0, 1'b0, rid);
        step(1);
        clr = 4'h0;
        step(1);
    endtask

    // monitor: one sample per cycle, 1 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (flag !== it.f || irq !== it.q || wake !== it.w) begin
                    fails++;
                    $display("FAIL %s cyc=%0d flag=%b/%b irq=%b/%b wake=%b/%b (actual/expected)",
                             it.rid, cyc, flag, it.f, irq, it.q, wake, it.w);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(8);
        expect_in(1, 4'h0, 4'h0, 1'b0, "R1"); step(2);

        // R2 falling edge on pad 0
        pin[0] = 1'b0;
        expect_in(2, 4'h0, 4'h0, 1'b0, "R2");
        expect_in(3, 4'h1, 4'h1, 1'b1, "R2");
        step(4);
        expect_in(1, 4'h1, 4'h1, 1'b1, "R6"); step(3);
        wipe(4'h1, "R6");
        pin[0] = 1'b1; expect_in(3, 4'h0, 4'h0, 1'b0, "R2"); step(4);

        // R3 rising edge on pad 1
        pin[1] = 1'b0; expect_in(3, 4'h0, 4'h0, 1'b0, "R3"); step(4);
        pin[1] = 1'b1; expect_in(3, 4'h2, 4'h2, 1'b1, "R3"); step(4);
        wipe(4'h2, "R3");

        // R4 any change on pad 2
        pin[2] = 1'b0; expect_in(3, 4'h4, 4'h4, 1'b1, "R4"); step(4);
        wipe(4'h4, "R4");
        pin[2] = 1'b1; expect_in(3, 4'h4, 4'h4, 1'b1, "R4"); step(4);
        wipe(4'h4, "R4");

        // R5 low level on pad 3, R9 wake follows
        pin[3] = 1'b0; expect_in(1, 4'h0, 4'h8, 1'b1, "R5"); step(2);
        en[3] = 1'b0;  expect_in(1, 4'h0, 4'h0, 1'b0, "R9"); step(2);
        en[3] = 1'b1;  expect_in(1, 4'h0, 4'h8, 1'b1, "R5"); step(2);
        pin[3] = 1'b1; expect_in(1, 4'h0, 4'h0, 1'b0, "R5"); step(2);

        // R8 enable gates the request, not the flag
        en[0] = 1'b0;
        pin[0] = 1'b0; expect_in(3, 4'h1, 4'h0, 1'b0, "R8"); step(4);
        en[0] = 1'b1;  expect_in(1, 4'h1, 4'h1, 1'b1, "R8"); step(2);
        wipe(4'h1, "R8");
        pin[0] = 1'b1; step(4);

        // R10 I/O clock gated off
        io_run = 1'b0; step(2);
        pin[0] = 1'b0; expect_in(6, 4'h0, 4'h0, 1'b0, "R10"); step(7);
        pin[3] = 1'b0; expect_in(1, 4'h0, 4'h8, 1'b1, "R5"); step(2);
        pin[3] = 1'b1; expect_in(1, 4'h0, 4'h0, 1'b0, "R5"); step(2);
        io_run = 1'b1; expect_in(8, 4'h0, 4'h0, 1'b0, "R10"); step(9);
        pin[0] = 1'b1; expect_in(3, 4'h0, 4'h0, 1'b0, "R10"); step(4);
        pin[0] = 1'b0; expect_in(3, 4'h1, 4'h1, 1'b1, "R10"); step(4);
        wipe(4'h1, "R10");

        // R7 set wins over a clear in the same cycle
        pin[0] = 1'b1; step(4);
        pin[0] = 1'b0; step(2);
        clr = 4'h1;
        expect_in(1, 4'h1, 4'h1, 1'b1, "R7");
        expect_in(2, 4'h1, 4'h1, 1'b1, "R7");
        step(1);
        clr = 4'h0; step(2);
        wipe(4'h1, "R7");

        // R11 switching to low level drops the flag
        pin[0] = 1'b1; step(4);
        pin[0] = 1'b0; expect_in(3, 4'h1, 4'h1, 1'b1, "R11"); step(4);
        sense[1:0] = 2'b00; expect_in(1, 4'h0, 4'h1, 1'b1, "R11"); step(2);
        pin[0] = 1'b1; expect_in(1, 4'h0, 4'h0, 1'b0, "R11"); step(2);
        sense[1:0] = 2'b10; step(4);

        step(5);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard left=%0d expected=0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule